// File: doc/BRIEF.md
# Dual-Bank Ping-Pong FIFO

This block moves data between a producer and a consumer that run on unrelated clocks. It does this in whole-bank handoffs, not one word at a time. Two equal storage banks sit inside it. The producer claims a bank, writes into it, and hands it over. The consumer then claims that same bank, drains it, and returns it. While the consumer drains one bank, the producer can fill the other.

Neither side ever sees an address. The producer learns how much room is left in the bank it holds. The consumer learns how many words remain in the bank it holds.

Banks are used in strict alternation on both sides, starting with bank 0. The number of words written into a bank travels with that bank, so a bank may be handed over partly filled, or even empty. Bank status crosses between the two clock domains through toggle flags and two-stage synchronizers. The per-bank word count is read by the consumer only after the bank's full flag has been synchronized into its domain.

Top module: `dbf_pingpong_fifo`

## Requirements
- R1: After reset, `wr_ready` is 2'b11, and `wr_grant`, `wr_space`, `rd_ready` and `rd_count` are all zero.
- R2: The first bank granted to the producer is bank 0 (`wr_grant` = 2'b01). After that, grants alternate between bank 1 (2'b10) and bank 0. At most one bit of `wr_grant` is set at any time.
- R3: A grant happens while `wr_req` is high and the next bank in order is empty. In the cycle the grant appears, `wr_space` equals the bank depth (8 by default). Each `wr_stb` accepted while granted lowers `wr_space` by one. The `wr_ready` bit of the granted bank reads 0 while the bank is owned.
- R4: A `wr_stb` is ignored in two cases: when no bank is granted, or when `wr_space` is 0. An ignored strobe changes no count and adds no word for the consumer.
- R5: The producer releases its bank by lowering `wr_req`. On the next edge `wr_grant` returns to zero. When the consumer later claims that bank, `rd_count` equals the number of words that were accepted.
- R6: `rd_ready` rises once a released bank has crossed to the read domain. The consumer claims the bank by raising `rd_act`. While the bank is held, `rd_data` shows the oldest unread word. Each `rd_stb` with `rd_count` > 0 pops one word and lowers `rd_count` by one. Words come out in the order they were written.
- R7: A bank is not granted to the producer again until the consumer has returned it. With both banks full, a held `wr_req` gets no grant and `wr_ready` stays 2'b00.
- R8: A `rd_stb` while `rd_count` is 0 has no effect; `rd_count` stays 0.
- R9: The consumer and the producer never hold the same bank at the same time.
- R10: Lowering `rd_act` returns the held bank to empty, even if words remain unread; those words are discarded. The next bank in order is the one offered next.
- R11: A bank released with no words written is still handed to the consumer, which sees `rd_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer synchronous reset, active low |
| wr_req | input | 1 | Held high to claim and keep a bank; lowered to release it |
| wr_stb | input | 1 | Write one word into the held bank |
| wr_data | input | DATA_W | Word to write |
| wr_ready | output | 2 | Per-bank empty flags in the producer domain |
| wr_grant | output | 2 | One-hot bank currently owned by the producer |
| wr_space | output | AW+1 | Words still writable into the held bank |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer synchronous reset, active low |
| rd_act | input | 1 | Held high to claim and keep a full bank; lowered to return it |
| rd_stb | input | 1 | Pop one word from the held bank |
| rd_data | output | DATA_W | Oldest unread word of the held bank |
| rd_ready | output | 1 | A full bank is waiting for the consumer |
| rd_count | output | AW+1 | Words left unread in the held bank |

## Verification
If a bank's status is wrong inside the block, the fault shows up at the ports within a few cycles. A grant may go to a bank still being drained, which is caught as a one-hot or ownership conflict. Or a held `wr_req` may never be granted, which is caught by the blocked-grant check. A word pointer or a captured count that is wrong shows up on the first pop. In that case `rd_count` on claim or the first `rd_data` word differs from what was written. A lost toggle across the domain boundary shows up as `rd_ready` or `wr_ready` never rising within the bench's polling window. Scenarios cover partial fills, full banks with extra strobes, zero-word banks, both banks blocked, and an early return by the consumer.

// File: rtl/dbf_pkg.sv
// Shared types for the dual-bank ping-pong FIFO.
package dbf_pkg;
    // Write-side view of a bank's life cycle.
    typedef enum logic [1:0] {
        BK_EMPTY = 2'd0,
        BK_FILL  = 2'd1,
        BK_FULL  = 2'd2
    } bank_st_e;
endpackage

// File: rtl/dbf_sync.sv
// Two-stage synchronizer, one per bit.
// Assumes each bit is a level or a toggle that is held for many
// destination cycles; multi-bit words are not made coherent.
module dbf_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops per bit into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dbf_bank_mem.sv
// Storage for two banks of 2**AW words each.
// Writes happen on the producer clock. Reads are combinational, so the
// read side sees the addressed word at once. The banks are small and
// built from registers.
module dbf_bank_mem #(
    parameter int DATA_W = 16,
    parameter int AW     = 3
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] bank_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Store a word when this bank is the write target.
        always_ff @(posedge wr_clk) begin
            if (we && (wbank == 1'(g))) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_q[g] = mem[raddr];
    end

    assign rdata = bank_q[rbank];
endmodule

// File: rtl/dbf_wr_ctrl.sv
// Producer-side bank arbiter and write pointer.
// Grants banks in strict alternation starting at bank 0. A bank is
// granted only once the consumer has returned it. On release, the
// written count is stored and the bank's full toggle flips. The count is
// held stable until the bank comes back empty. Assumes empty_tog_s is
// already synchronized to wr_clk.
module dbf_wr_ctrl
    import dbf_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic               wr_clk,
    input  logic               wr_rst_n,
    input  logic               wr_req,
    input  logic               wr_stb,
    input  logic [1:0]         empty_tog_s,
    output logic [1:0]         wr_ready,
    output logic [1:0]         wr_grant,
    output logic [AW:0]        wr_space,
    output logic               mem_we,
    output logic               mem_bank,
    output logic [AW-1:0]      mem_addr,
    output logic [1:0]         full_tog,
    output logic [1:0][AW:0]   bank_cnt,
    output logic               hold,
    output logic               cur
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    bank_st_e    st [2];
    logic        nxt;
    logic [AW:0] ptr;
    logic [1:0]  empty_seen;
    logic [1:0]  empty_evt;
    logic        accept;

    assign empty_evt = empty_tog_s ^ empty_seen;
    assign accept    = hold && wr_req && wr_stb && (ptr != FULL_CNT);

    // Bank states, grant/release sequencing and the write pointer.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            for (int b = 0; b < 2; b++) begin
                st[b]       <= BK_EMPTY;
                bank_cnt[b] <= '0;
            end
            hold       <= 1'b0;
            cur        <= 1'b0;
            nxt        <= 1'b0;
            ptr        <= '0;
            full_tog   <= '0;
            empty_seen <= '0;
        end else begin
            empty_seen <= empty_tog_s;
            for (int b = 0; b < 2; b++) begin
                if (empty_evt[b]) begin
                    st[b] <= BK_EMPTY;
                end
            end
            if (!hold) begin
                if (wr_req && (st[nxt] == BK_EMPTY)) begin
                    hold    <= 1'b1;
                    cur     <= nxt;
                    ptr     <= '0;
                    st[nxt] <= BK_FILL;
                end
            end else if (!wr_req) begin
                bank_cnt[cur] <= ptr;
                st[cur]       <= BK_FULL;
                full_tog[cur] <= ~full_tog[cur];
                hold          <= 1'b0;
                nxt           <= ~cur;
            end else if (accept) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // Status and grant outputs.
    always_comb begin
        for (int b = 0; b < 2; b++) begin
            wr_ready[b] = (st[b] == BK_EMPTY);
            wr_grant[b] = hold && (cur == 1'(b));
        end
        wr_space = hold ? (FULL_CNT - ptr) : '0;
    end

    assign mem_we   = accept;
    assign mem_bank = cur;
    assign mem_addr = ptr[AW-1:0];
endmodule

// File: rtl/dbf_rd_ctrl.sv
// Consumer-side bank tracker and read pointer.
// Takes banks in the same alternating order as the producer. The
// written count is sampled only after the bank's full toggle has been
// synchronized, so the count has been stable for at least two cycles.
// Lowering rd_act returns the bank and flips its empty toggle.
module dbf_rd_ctrl #(
    parameter int AW = 3
) (
    input  logic               rd_clk,
    input  logic               rd_rst_n,
    input  logic               rd_act,
    input  logic               rd_stb,
    input  logic [1:0]         full_tog_s,
    input  logic [1:0][AW:0]   cnt_in,
    output logic               rd_ready,
    output logic [AW:0]        rd_count,
    output logic               mem_bank,
    output logic [AW-1:0]      mem_addr,
    output logic [1:0]         empty_tog,
    output logic               hold,
    output logic               cur
);
    logic [1:0]  full_seen;
    logic [1:0]  full_evt;
    logic [1:0]  avail;
    logic [AW:0] ptr;
    logic [AW:0] cnt_q;

    assign full_evt = full_tog_s ^ full_seen;

    // Track full banks, claim/return sequencing and the read pointer.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            full_seen <= '0;
            avail     <= '0;
            hold      <= 1'b0;
            cur       <= 1'b0;
            ptr       <= '0;
            cnt_q     <= '0;
            empty_tog <= '0;
        end else begin
            full_seen <= full_tog_s;
            for (int b = 0; b < 2; b++) begin
                if (full_evt[b]) begin
                    avail[b] <= 1'b1;
                end
            end
            if (!hold) begin
                if (rd_act && avail[cur]) begin
                    hold  <= 1'b1;
                    ptr   <= '0;
                    cnt_q <= cnt_in[cur];
                end
            end else if (!rd_act) begin
                hold           <= 1'b0;
                avail[cur]     <= 1'b0;
                empty_tog[cur] <= ~empty_tog[cur];
                cur            <= ~cur;
            end else if (rd_stb && (ptr != cnt_q)) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    assign rd_ready = avail[cur] && !hold;
    assign rd_count = hold ? (cnt_q - ptr) : '0;
    assign mem_bank = cur;
    assign mem_addr = ptr[AW-1:0];
endmodule

// File: rtl/dbf_pingpong_fifo.sv
// Dual-bank ping-pong FIFO top level.
// Joins the producer arbiter, the consumer tracker, the bank storage and
// the two toggle synchronizers. The producer and consumer clocks are
// assumed to be unrelated.
module dbf_pingpong_fifo #(
    parameter int DATA_W = 16,
    parameter int AW     = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_req,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        wr_ready,
    output logic [1:0]        wr_grant,
    output logic [AW:0]       wr_space,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_act,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready,
    output logic [AW:0]       rd_count
);
    logic             mem_we;
    logic             w_bank;
    logic [AW-1:0]    w_addr;
    logic             r_bank;
    logic [AW-1:0]    r_addr;
    logic [1:0]       full_tog;
    logic [1:0]       full_tog_s;
    logic [1:0]       empty_tog;
    logic [1:0]       empty_tog_s;
    logic [1:0][AW:0] bank_cnt;
    logic             wr_hold;
    logic             wr_cur;
    logic             rd_hold;
    logic             rd_cur;

    dbf_wr_ctrl #(.AW(AW)) u_wr (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_req      (wr_req),
        .wr_stb      (wr_stb),
        .empty_tog_s (empty_tog_s),
        .wr_ready    (wr_ready),
        .wr_grant    (wr_grant),
        .wr_space    (wr_space),
        .mem_we      (mem_we),
        .mem_bank    (w_bank),
        .mem_addr    (w_addr),
        .full_tog    (full_tog),
        .bank_cnt    (bank_cnt),
        .hold        (wr_hold),
        .cur         (wr_cur)
    );

    dbf_rd_ctrl #(.AW(AW)) u_rd (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .rd_act     (rd_act),
        .rd_stb     (rd_stb),
        .full_tog_s (full_tog_s),
        .cnt_in     (bank_cnt),
        .rd_ready   (rd_ready),
        .rd_count   (rd_count),
        .mem_bank   (r_bank),
        .mem_addr   (r_addr),
        .empty_tog  (empty_tog),
        .hold       (rd_hold),
        .cur        (rd_cur)
    );

    dbf_sync #(.W(2)) u_full_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (full_tog),
        .q     (full_tog_s)
    );

    dbf_sync #(.W(2)) u_empty_sync (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (empty_tog),
        .q     (empty_tog_s)
    );

    dbf_bank_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .wbank  (w_bank),
        .waddr  (w_addr),
        .wdata  (wr_data),
        .rbank  (r_bank),
        .raddr  (r_addr),
        .rdata  (rd_data)
    );
endmodule

// File: rtl/dbf_pingpong_fifo_chk.sv
// Property checker for dbf_pingpong_fifo, attached with bind.
// Observes the producer and consumer ports and the bank each side holds.
module dbf_pingpong_fifo_chk #(
    parameter int AW = 3
) (
    input logic        wr_clk,
    input logic        wr_rst_n,
    input logic        wr_req,
    input logic        wr_stb,
    input logic [1:0]  wr_ready,
    input logic [1:0]  wr_grant,
    input logic [AW:0] wr_space,
    input logic        rd_clk,
    input logic        rd_rst_n,
    input logic        rd_act,
    input logic        rd_stb,
    input logic [AW:0] rd_count,
    input logic        wr_hold,
    input logic        wr_cur,
    input logic        rd_hold,
    input logic        rd_cur
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    // R2
    grant_onehot_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $onehot0(wr_grant));

    // R7
    grant0_needs_empty_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(wr_grant[0]) |-> $past(wr_ready[0]));

    // R7
    grant1_needs_empty_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(wr_grant[1]) |-> $past(wr_ready[1]));

    // R3
    space_at_grant_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(|wr_grant) |-> (wr_space == FULL_CNT));

    // R3
    space_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ((|wr_grant) && wr_req && wr_stb && (wr_space != '0))
        |=> (wr_space == $past(wr_space) - 1'b1));

    // R4
    full_ignore_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ((|wr_grant) && wr_req && wr_stb && (wr_space == '0)) |=> (wr_space == '0));

    // R9
    bank_exclusive_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        !(wr_hold && rd_hold && (wr_cur == rd_cur)));

    // R6
    rd_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_act && rd_stb && (rd_count != '0)) |=> (rd_count == $past(rd_count) - 1'b1));

    // R8
    rd_empty_ignore_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_hold && rd_act && rd_stb && (rd_count == '0)) |=> (rd_count == '0));
endmodule

bind dbf_pingpong_fifo dbf_pingpong_fifo_chk #(.AW(AW)) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_req   (wr_req),
    .wr_stb   (wr_stb),
    .wr_ready (wr_ready),
    .wr_grant (wr_grant),
    .wr_space (wr_space),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_act   (rd_act),
    .rd_stb   (rd_stb),
    .rd_count (rd_count),
    .wr_hold  (wr_hold),
    .wr_cur   (wr_cur),
    .rd_hold  (rd_hold),
    .rd_cur   (rd_cur)
);

// File: tb/dbf_pingpong_fifo_tb.sv
// Directed bench for dbf_pingpong_fifo: producer at 100 MHz, consumer on
// an unrelated 14 ns clock.
module dbf_pingpong_fifo_tb;
    localparam int DATA_W = 16;
    localparam int AW     = 3;
    localparam int DEPTH  = 1 << AW;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_req = 1'b0;
    logic              wr_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        wr_ready;
    logic [1:0]        wr_grant;
    logic [AW:0]       wr_space;
    logic              rd_act = 1'b0;
    logic              rd_stb = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_ready;
    logic [AW:0]       rd_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dbf_pingpong_fifo #(.DATA_W(DATA_W), .AW(AW)) u_dut (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_req   (wr_req),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .wr_grant (wr_grant),
        .wr_space (wr_space),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_act   (rd_act),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data),
        .rd_ready (rd_ready),
        .rd_count (rd_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Claim a bank and check the grant pattern and initial space.
    task automatic wr_grab(input int exp_grant, input string req);
        int waited = 0;
        @(negedge wr_clk);
        wr_req = 1'b1;
        do begin
            @(negedge wr_clk);
            waited++;
        end while (wr_grant == 2'b00 && waited < 60);
        check(req, int'(wr_grant), exp_grant);
        check("R3 space at grant", int'(wr_space), DEPTH);
        check("R3 owned bank not ready", int'(wr_ready & wr_grant), 0);
    endtask

    // Write n words starting at base.
    task automatic wr_push(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            wr_stb  = 1'b1;
            wr_data = DATA_W'(base + i);
            @(negedge wr_clk);
        end
        wr_stb = 1'b0;
    endtask

    // Release the held bank.
    task automatic wr_drop();
        wr_req = 1'b0;
        @(negedge wr_clk);
        check("R5 grant cleared on release", int'(wr_grant), 0);
    endtask

    // Wait for a full bank, claim it, and check its count.
    task automatic rd_take(input int exp_cnt, input string req);
        int waited = 0;
        @(negedge rd_clk);
        while (!rd_ready && waited < 60) begin
            @(negedge rd_clk);
            waited++;
        end
        check("R6 rd_ready rises", int'(rd_ready), 1);
        rd_act = 1'b1;
        @(negedge rd_clk);
        check(req, int'(rd_count), exp_cnt);
    endtask

    // Pop n words and compare them against base+i.
    task automatic rd_drain(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            check("R6 data order", int'(rd_data), base + i);
            rd_stb = 1'b1;
            @(negedge rd_clk);
        end
        rd_stb = 1'b0;
    endtask

    // Return the held bank.
    task automatic rd_drop();
        rd_act = 1'b0;
        @(negedge rd_clk);
        @(negedge rd_clk);
    endtask

    // R1: reset values.
    task automatic t_reset();
        check("R1 wr_ready", int'(wr_ready), 3);
        check("R1 wr_grant", int'(wr_grant), 0);
        check("R1 wr_space", int'(wr_space), 0);
        check("R1 rd_ready", int'(rd_ready), 0);
        check("R1 rd_count", int'(rd_count), 0);
    endtask

    // R2, R3, R5, R6, R8: partial fill of bank 0.
    task automatic t_basic();
        wr_grab(1, "R2 first grant is bank 0");
        wr_push(5, 16'h1000);
        check("R3 space after 5 writes", int'(wr_space), DEPTH - 5);
        wr_drop();
        check("R7 bank 0 busy after release", int'(wr_ready), 2);
        rd_take(5, "R5 count of partial bank");
        rd_drain(5, 16'h1000);
        check("R6 count after drain", int'(rd_count), 0);
        rd_stb = 1'b1;
        @(negedge rd_clk);
        @(negedge rd_clk);
        rd_stb = 1'b0;
        check("R8 pop on empty ignored", int'(rd_count), 0);
        rd_drop();
    endtask

    // R2, R4: stray strobes, then a full bank with extra strobes.
    task automatic t_ignore();
        @(negedge wr_clk);
        wr_stb = 1'b1;
        wr_data = 16'hDEAD;
        repeat (3) @(negedge wr_clk);
        wr_stb = 1'b0;
        check("R4 no grant from stray strobe", int'(wr_grant), 0);
        wr_grab(2, "R2 second grant is bank 1");
        wr_push(DEPTH, 16'h2000);
        check("R4 space zero when full", int'(wr_space), 0);
        wr_push(2, 16'hBEEF);
        check("R4 space stays zero", int'(wr_space), 0);
        wr_drop();
        rd_take(DEPTH, "R4 extra strobes not counted");
        rd_drain(DEPTH, 16'h2000);
        rd_drop();
    endtask

    // R7, R11: both banks full block the writer; zero-word release.
    task automatic t_block();
        wr_grab(1, "R2 third grant is bank 0");
        wr_push(2, 16'h3000);
        wr_drop();
        wr_grab(2, "R2 fourth grant is bank 1");
        wr_push(3, 16'h3100);
        wr_drop();
        wr_req = 1'b1;
        repeat (30) @(negedge wr_clk);
        check("R7 no grant while both full", int'(wr_grant), 0);
        check("R7 no bank ready", int'(wr_ready), 0);
        rd_take(2, "R5 bank 0 count");
        rd_drain(2, 16'h3000);
        rd_drop();
        wr_grab(1, "R7 grant after return");
        wr_drop();
        rd_take(3, "R5 bank 1 count");
        rd_drain(3, 16'h3100);
        rd_drop();
        rd_take(0, "R11 zero-word bank");
        rd_drop();
    endtask

    // R10: early return discards remaining words.
    task automatic t_early();
        int waited = 0;
        wr_grab(2, "R2 bank 1 after zero-word bank");
        wr_push(4, 16'h4000);
        wr_drop();
        rd_take(4, "R5 count before early return");
        rd_drain(1, 16'h4000);
        check("R10 remaining before return", int'(rd_count), 3);
        rd_drop();
        @(negedge wr_clk);
        while (wr_ready != 2'b11 && waited < 60) begin
            @(negedge wr_clk);
            waited++;
        end
        check("R10 bank empty after early return", int'(wr_ready), 3);
        wr_grab(1, "R10 next grant bank 0");
        wr_push(1, 16'h5000);
        wr_drop();
        rd_take(1, "R10 next bank count");
        rd_drain(1, 16'h5000);
        rd_drop();
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        t_reset();
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        t_basic();
        t_ignore();
        t_block();
        t_early();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule